// File: doc/BRIEF.md
# Subtract-and-swap greatest common divisor engine

This block finds the greatest common divisor of two unsigned operands by Euclid's method. It uses repeated subtraction only: there is no divider. Two working registers, called the minuend x and the keeper y, hold the state of the job. Each clock cycle the block takes one step:

- If x is at least y, x drops by y.
- Otherwise, if x is nonzero, the two registers trade places.
- If x is zero, the step changes nothing.

The job is done when x reaches zero, and the answer is then in y.

A caller first waits for the busy flag to be low. It then raises the start strobe for one cycle with both operands. The ready flag is high whenever x is zero, and the result port then carries the answer. A start raised while the engine is busy is dropped, and an error flag pulses for one cycle. A second operand of zero is remapped when the operands load, so that the job ends at once with the first operand as its answer.

Top module: `subswap_gcd`

## Requirements
- R1: After a synchronous reset, busy is 0, ready is 1, result is 0 and err is 0.
- R2: A start sampled while busy is low, with both operands nonzero, loads x from opa and y from opb. From the next cycle, result equals opb and busy equals 1.
- R3: On a step cycle where x is at least y and x is nonzero, x becomes x minus y and result (y) is unchanged.
- R4: On a step cycle where x is nonzero and below y, x and y exchange values, so result takes the old x.
- R5: While ready is 1 and no start is sampled, ready stays 1 and result holds its value, whatever the operand inputs do.
- R6: Busy is 1 exactly when x is nonzero, ready is its complement, and result always equals y.
- R7: When ready returns to 1 after a job, result equals the greatest common divisor of the two loaded operands.
- R8: A start sampled while busy is 1 changes neither x nor y beyond the normal step. It drives err to 1 in the next cycle only. err is 0 in any cycle that does not follow such a start.
- R9: Zero operands: (0,0) gives ready with result 0 in the next cycle. (0,b) gives ready with result b. (a,0) with a nonzero gives ready with result a, and both take no step cycles.
- R10: For operands 15 and 6, busy stays high for exactly five cycles after the load: subtract, subtract, swap, subtract, subtract. The job then ends with result 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to load new operands |
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand |
| busy_o | output | 1 | Job in progress (x nonzero) |
| ready_o | output | 1 | Result valid (x zero) |
| result_o | output | W | Current keeper register value |
| err_o | output | 1 | One-cycle pulse after a start refused while busy |

## Verification
The hardest case to reach is a start that arrives in the middle of a job. The bench must show that this start leaves the step sequence untouched and still raises the error pulse. To reach it, the bench loads operands that need many steps, 100 and 7. It then raises start with unrelated operands a few cycles in, once while the engine is subtracting and once for two cycles in a row. The per-clock reference model shows that every step and the final divisor are unchanged. Long chains of swaps and subtracts come from random operand pairs. Wide operands are chosen so that the job still finishes in a few cycles.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  // Action taken by the step logic in one cycle.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SUB  = 2'd1,
    ACT_SWAP = 2'd2
  } gcd_act_e;

endpackage

// File: rtl/gcd_step_decide.sv
module gcd_step_decide
  import gcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x_q,
  input  logic [W-1:0] y_q,
  output gcd_act_e     act,
  output logic [W-1:0] diff
);

  logic x_geq_y;
  logic x_nz;

  always_comb begin
    x_geq_y = (x_q >= y_q);
    x_nz    = |x_q;
    diff    = x_q - y_q;
    if (!x_nz)        act = ACT_HOLD;
    else if (x_geq_y) act = ACT_SUB;
    else              act = ACT_SWAP;
  end

endmodule

// File: rtl/gcd_start_ctrl.sv
module gcd_start_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic busy_q,
  output logic load_en,
  output logic err_q
);

  assign load_en = start_i & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= start_i & busy_q;
  end

endmodule

// File: rtl/gcd_operand_regs.sv
module gcd_operand_regs
  import gcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  gcd_act_e     act,
  input  logic [W-1:0] diff,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic         busy_q,
  output logic         ready_q
);

  logic [W-1:0] x_nx;
  logic [W-1:0] y_nx;

  always_comb begin
    x_nx = x_q;
    y_nx = y_q;
    if (load_en) begin
      // A zero second operand would never let x reach zero: remap it.
      if (opb_i == '0) begin
        x_nx = '0;
        y_nx = opa_i;
      end else begin
        x_nx = opa_i;
        y_nx = opb_i;
      end
    end else begin
      case (act)
        ACT_SUB:  x_nx = diff;
        ACT_SWAP: begin
          x_nx = y_q;
          y_nx = x_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q     <= '0;
      y_q     <= '0;
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      x_q     <= x_nx;
      y_q     <= y_nx;
      busy_q  <= |x_nx;
      ready_q <= ~|x_nx;
    end
  end

endmodule

// File: rtl/subswap_gcd.sv
module subswap_gcd
  import gcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         ready_o,
  output logic [W-1:0] result_o,
  output logic         err_o
);

  logic         load_en;
  logic         busy_q;
  logic         ready_q;
  logic         err_q;
  logic [W-1:0] x_q;
  logic [W-1:0] y_q;
  logic [W-1:0] diff;
  gcd_act_e     act;

  gcd_start_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_q  (busy_q),
    .load_en (load_en),
    .err_q   (err_q)
  );

  gcd_step_decide #(.W(W)) u_decide (
    .x_q  (x_q),
    .y_q  (y_q),
    .act  (act),
    .diff (diff)
  );

  gcd_operand_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .act     (act),
    .diff    (diff),
    .x_q     (x_q),
    .y_q     (y_q),
    .busy_q  (busy_q),
    .ready_q (ready_q)
  );

  assign busy_o   = busy_q;
  assign ready_o  = ready_q;
  assign result_o = y_q;
  assign err_o    = err_q;

endmodule

// File: rtl/subswap_gcd_chk.sv
module subswap_gcd_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         busy_o,
  input logic         ready_o,
  input logic [W-1:0] result_o,
  input logic         err_o
);

  // R6: the two status flags are always complementary
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
    busy_o != ready_o);

  // R8: refused start raises err in the next cycle
  p_err_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> err_o);

  // R8: err only follows a refused start
  p_err_only_r8: assert property (@(posedge clk) disable iff (rst)
    !(start_i && busy_o) |=> !err_o);

  // R5: idle engine holds its answer
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !start_i) |=> (ready_o && $stable(result_o)));

  // R2: accepted start with nonzero operands shows opb and goes busy
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && opa_i != '0 && opb_i != '0)
      |=> (busy_o && result_o == $past(opb_i)));

  // R9: zero second operand finishes at once with the first operand
  p_zero_b_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && opb_i == '0)
      |=> (ready_o && result_o == $past(opa_i)));

endmodule

bind subswap_gcd subswap_gcd_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .busy_o   (busy_o),
  .ready_o  (ready_o),
  .result_o (result_o),
  .err_o    (err_o)
);

// File: tb/subswap_gcd_tb_top.sv
module subswap_gcd_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic         busy_o;
  logic         ready_o;
  logic [W-1:0] result_o;
  logic         err_o;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [W-1:0] mx = '0;
  logic [W-1:0] my = '0;
  logic         merr = 1'b0;
  string        mtag = "R1";

  always #4 clk = ~clk;

  subswap_gcd #(.W(W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .busy_o   (busy_o),
    .ready_o  (ready_o),
    .result_o (result_o),
    .err_o    (err_o)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    summary();
    $finish;
  end

  function automatic logic [W-1:0] soft_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] p = a;
    logic [W-1:0] q = b;
    while (q != 0) begin
      logic [W-1:0] t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: advance the model with the inputs seen at the edge, then compare.
  task automatic cycle();
    @(posedge clk);
    if (rst) begin
      mx = '0; my = '0; merr = 1'b0; mtag = "R1";
    end else begin
      merr = start_i && (mx != 0);
      if (start_i && mx == 0) begin
        mtag = (opb_i == 0 || opa_i == 0) ? "R9" : "R2";
        if (opb_i == 0) begin mx = '0; my = opa_i; end
        else begin mx = opa_i; my = opb_i; end
      end else if (mx != 0) begin
        if (mx >= my) begin mx = mx - my; mtag = "R3"; end
        else begin
          logic [W-1:0] t = mx;
          mx = my; my = t; mtag = "R4";
        end
        if (merr) mtag = "R8";
      end else begin
        mtag = "R5";
      end
    end
    #2;
    check(busy_o == (mx != 0) && ready_o == (mx == 0) && result_o == my && err_o == merr,
          mtag, "busy/ready/err/result vs model (R6)",
          {busy_o, ready_o, err_o, result_o[W-4:0]},
          {(mx != 0), (mx == 0), merr, my[W-4:0]});
  endtask

  task automatic run_job(input logic [W-1:0] a, input logic [W-1:0] b, output int steps);
    start_i = 1'b1; opa_i = a; opb_i = b;
    cycle();
    start_i = 1'b0;
    steps = 0;
    while (busy_o && steps < 20000) begin
      cycle();
      steps++;
    end
    check(ready_o && result_o == soft_gcd(a, b), "R7", "final divisor",
          result_o, soft_gcd(a, b));
  endtask

  initial begin
    int st;
    logic [W-1:0] held;
    cycle();
    cycle();
    rst = 1'b0;
    #1;
    // R1: reset state
    check(!busy_o && ready_o && result_o == 0 && !err_o, "R1", "reset state",
          {busy_o, ready_o, err_o}, 3'b010);

    // R10: worked sequence 15,6
    run_job(32'd15, 32'd6, st);
    check(st == 5, "R10", "step count for 15,6", st, 5);
    check(result_o == 3, "R10", "result for 15,6", result_o, 3);

    // R9: zero operands
    run_job(32'd0, 32'd0, st);
    check(st == 0 && result_o == 0, "R9", "0,0", result_o, 0);
    run_job(32'd0, 32'd7, st);
    check(st == 0 && result_o == 7, "R9", "0,7", result_o, 7);
    run_job(32'd9, 32'd0, st);
    check(st == 0 && result_o == 9, "R9", "9,0", result_o, 9);

    // R5: idle with wiggling operands, no start
    held = result_o;
    for (int i = 0; i < 6; i++) begin
      opa_i = $urandom; opb_i = $urandom;
      cycle();
    end
    check(ready_o && result_o == held, "R5", "idle hold", result_o, held);

    // R8: start while busy is refused
    start_i = 1'b1; opa_i = 32'd100; opb_i = 32'd7;
    cycle();
    start_i = 1'b0;
    cycle(); cycle();
    start_i = 1'b1; opa_i = 32'd55; opb_i = 32'd11;
    cycle();
    start_i = 1'b0;
    check(err_o == 1'b1, "R8", "err after refused start", err_o, 1);
    cycle();
    check(err_o == 1'b0, "R8", "err single pulse", err_o, 0);
    start_i = 1'b1; opa_i = 32'd8; opb_i = 32'd4;
    cycle(); cycle();
    start_i = 1'b0;
    while (busy_o) cycle();
    check(result_o == 1, "R8", "job undisturbed (gcd 100,7)", result_o, 1);

    // R3/R4: wide corner operands finishing quickly
    run_job(32'hFFFF_FFFF, 32'hFFFF_FFFF, st);
    run_job(32'h8000_0000, 32'h4000_0000, st);
    run_job(32'h4000_0000, 32'h8000_0000, st);
    run_job(32'hFFFF_FFF0, 32'h7FFF_FFF8, st);

    // random pairs
    for (int i = 0; i < 30; i++) begin
      run_job($urandom_range(2000, 1), $urandom_range(2000, 1), st);
    end

    summary();
    $finish;
  end

endmodule